// File: doc/BRIEF.md
# MDIO Host Frame Engine

This block is the host side of a two-wire PHY management link. A request gives a 2-bit operation code, a 5-bit port address, a 5-bit device type and a 16-bit payload. From these the block builds a 64-bit management frame and shifts it out MSB first on a bidirectional data line, together with a management clock (MDC) made by dividing the system clock.

Each frame has 32 preamble ones, the start pair, the opcode, the port address, the device type, a 2-bit turnaround and a 16-bit field. Address and write frames are driven by the host from the first bit to the last. On read frames the host releases the line at the turnaround. It then samples the 16 bits the target returns at the very end of each MDC high phase. When the frame ends, it presents the captured word with a one-cycle done pulse.

The data line is split into a driven value, an output enable and a sensed input, so an I/O pad can join them. A start request is accepted only while the engine is idle. The clock divider value is captured when the request is accepted.

Top module: `mdio_frame_host`

## Requirements
- R1: After reset and whenever no frame is in progress, `mdc`, `busy`, `done` and `mdio_oe` are all 0. `rd_data` resets to 0.
- R2: Frame bit 0 is sent first, and bit k carries bit 63-k of the frame word. Bits 0 to 31 are 1, and bits 32 and 33 (the start pair) are 0.
- R3: Bits 34 and 35 carry `op` MSB first, with 00 = address, 01 = write, 10 = read with address post-increment and 11 = read. Bits 36 to 40 carry `port_addr` MSB first, and bits 41 to 45 carry `dev_type` MSB first.
- R4: For `op` 00 and 01, `mdio_oe` is 1 for all 64 bits. Bits 46 and 47 are 1 and 0, and bits 48 to 63 carry `wr_data` MSB first.
- R5: For `op` 10 and 11, `mdio_oe` is 1 for bits 0 to 45 and 0 from bit 46 through bit 63. Once it has dropped within a frame, it does not rise again before the frame ends.
- R6: On a read, `mdio_i` is sampled in the last system-clock cycle of the MDC high phase of bits 48 to 63. The 16 samples form `rd_data`, with the bit-48 sample as the MSB.
- R7: Each bit lasts 2*(`div_half`+1) system cycles: MDC is low for the first half and high for the second. `mdio_o` and `mdio_oe` change only at the edge where MDC falls, and stay constant while MDC is high.
- R8: `busy` rises in the cycle after an accepted `start` and stays high for exactly 128*(`div_half`+1) cycles. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R9: A `start` while `busy` is high is ignored. The frame in progress continues unchanged, and no second frame follows it.
- R10: `rd_data` changes only together with `done` at the end of a read frame. Address and write frames leave it holding the previous read result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a frame; accepted only when idle |
| op | input | 2 | Operation code (00 addr, 01 write, 10 read-inc, 11 read) |
| port_addr | input | 5 | Port address field |
| dev_type | input | 5 | Device type field |
| wr_data | input | 16 | Address or write data for address/write frames |
| div_half | input | DIV_W | MDC half period minus one, in system cycles |
| mdc | output | 1 | Management clock, idles low |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Value sensed on the data line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Data captured by the last read frame |

## Verification
The bench builds the engine with the default DIV_W of 8 and drives `div_half` values of 0, 1, 2 and 5. This keeps each frame between 128 and 768 cycles while covering both a one-cycle MDC high phase and a multi-cycle one. The target model in the bench changes its data only after MDC rises, so read data is correct only if the host samples late in the bit period. Each vector mixes the four opcodes with port and device extremes and with payload patterns that have an edge bit set or clear.

// File: rtl/mdio_host_pkg.sv
package mdio_host_pkg;

    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;
    localparam int DATA_BITS  = 16;

    typedef enum logic [1:0] {
        OP_ADDR     = 2'b00,
        OP_WRITE    = 2'b01,
        OP_READ_INC = 2'b10,
        OP_READ     = 2'b11
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e              op;
        logic [4:0]            port;
        logic [4:0]            dev;
        logic [DATA_BITS-1:0]  payload;
    } mdio_req_t;

    function automatic logic op_is_read(input mdio_op_e op);
        return (op == OP_READ) || (op == OP_READ_INC);
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_req_t r);
        logic [1:0]           ta;
        logic [DATA_BITS-1:0] body;
        ta   = op_is_read(r.op) ? 2'b11 : 2'b10;
        body = op_is_read(r.op) ? {DATA_BITS{1'b1}} : r.payload;
        return {32'hFFFF_FFFF, 2'b00, r.op, r.port, r.dev, ta, body};
    endfunction

endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             mdc,
    output logic             bit_end
);
    logic [DIV_W-1:0] cnt_q;
    logic             high_q;
    logic             half_done;

    assign half_done = (cnt_q == half_len);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q  <= '0;
            high_q <= 1'b0;
        end else if (half_done) begin
            cnt_q  <= '0;
            high_q <= !high_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign mdc     = high_q;
    assign bit_end = run && high_q && half_done;
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_host_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  rd_frame,
    input  logic                  active,
    input  logic                  advance,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  in_data,
    output logic                  last_bit
);
    logic [FRAME_BITS-1:0] sreg_q;
    logic [IDX_W-1:0]      idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            sreg_q <= frame;
            idx_q  <= '0;
        end else if (advance) begin
            sreg_q <= {sreg_q[FRAME_BITS-2:0], 1'b1};
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign mdio_o   = sreg_q[FRAME_BITS-1];
    assign mdio_oe  = active && !(rd_frame && (idx_q >= IDX_W'(TA_FIRST)));
    assign in_data  = (idx_q >= IDX_W'(DATA_FIRST));
    assign last_bit = (idx_q == IDX_W'(FRAME_BITS-1));
endmodule

// File: rtl/mdio_read_capture.sv
module mdio_read_capture
    import mdio_host_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample,
    input  logic                 final_bit,
    input  logic                 mdio_i,
    output logic [DATA_BITS-1:0] rd_data
);
    logic [DATA_BITS-1:0] cap_q;
    logic [DATA_BITS-1:0] cap_next;

    assign cap_next = {cap_q[DATA_BITS-2:0], mdio_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q   <= '0;
            rd_data <= '0;
        end else if (sample) begin
            cap_q <= cap_next;
            if (final_bit) rd_data <= cap_next;
        end
    end
endmodule

// File: rtl/mdio_frame_host.sv
module mdio_frame_host
    import mdio_host_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [4:0]       port_addr,
    input  logic [4:0]       dev_type,
    input  logic [15:0]      wr_data,
    input  logic [DIV_W-1:0] div_half,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rd_data
);
    mdio_req_t        req;
    logic             accept;
    logic [DIV_W-1:0] half_q;
    logic             rd_q;
    logic             bit_end;
    logic             in_data;
    logic             last_bit;
    logic             finish;

    always_comb begin
        req.op      = mdio_op_e'(op);
        req.port    = port_addr;
        req.dev     = dev_type;
        req.payload = wr_data;
    end

    assign accept = start && !busy;
    assign finish = busy && bit_end && last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            half_q <= '0;
            rd_q   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= 1'b1;
                half_q <= div_half;
                rd_q   <= op_is_read(req.op);
            end else if (finish) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    mdio_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .half_len (half_q),
        .mdc      (mdc),
        .bit_end  (bit_end)
    );

    mdio_frame_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .frame    (build_frame(req)),
        .rd_frame (rd_q),
        .active   (busy),
        .advance  (busy && bit_end),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .in_data  (in_data),
        .last_bit (last_bit)
    );

    mdio_read_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .sample    (busy && bit_end && rd_q && in_data),
        .final_bit (last_bit),
        .mdio_i    (mdio_i),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/mdio_frame_host_chk.sv
module mdio_frame_host_chk (
    input logic        clk,
    input logic        rst,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data
);
    assert_mdc_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    assert_oe_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    assert_oe_stays_released_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(mdio_oe)) |-> !mdio_oe);

    assert_hold_while_high_R7: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_rd_update_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_data) |-> done);
endmodule

bind mdio_frame_host mdio_frame_host_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data)
);

// File: tb/mdio_frame_host_tb_top.sv
module mdio_frame_host_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [4:0]  port_addr = '0;
    logic [4:0]  dev_type = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  div_half = '0;
    logic        mdc, mdio_o, mdio_oe, busy, done;
    logic [15:0] rd_data;
    logic        tgt = 1'b1;
    logic        mdio_line;

    int checks = 0;
    int fails  = 0;

    logic        line_bits [64];
    logic        oe_bits   [64];
    int          rise_cnt = 0;
    logic        mdc_prev = 1'b0;
    logic        tgt_rd = 1'b0;
    logic [15:0] tgt_data = '0;
    logic [15:0] last_rd = '0;

    always #10 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : tgt;

    mdio_frame_host dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .port_addr(port_addr),
        .dev_type(dev_type), .wr_data(wr_data), .div_half(div_half),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    // Target model: records each bit at MDC rise, then drives its reply after the rise.
    always @(negedge clk) begin
        if (mdc && !mdc_prev) begin
            if (rise_cnt < 64) begin
                line_bits[rise_cnt] = mdio_line;
                oe_bits[rise_cnt]   = mdio_oe;
            end
            if (tgt_rd) begin
                if (rise_cnt == 47)
                    tgt = 1'b0;
                else if (rise_cnt >= 48 && rise_cnt < 64)
                    tgt = tgt_data[63 - rise_cnt];
                else
                    tgt = 1'b1;
            end
            rise_cnt = rise_cnt + 1;
        end
        mdc_prev = mdc;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [1:0] f_op, input logic [4:0] f_port,
                             input logic [4:0] f_dev, input logic [15:0] f_data,
                             input logic [7:0] f_half, input bit inject);
        logic [63:0] exp;
        logic [63:0] got_line;
        logic [63:0] got_oe;
        logic [63:0] exp_oe;
        logic [63:0] mask;
        bit          is_rd;
        int          cycles;
        is_rd = f_op[1];
        exp = {32'hFFFF_FFFF, 2'b00, f_op, f_port, f_dev,
               is_rd ? 2'b11 : 2'b10, is_rd ? 16'hFFFF : f_data};
        @(negedge clk);
        op = f_op; port_addr = f_port; dev_type = f_dev; wr_data = f_data;
        div_half = f_half; tgt_rd = is_rd; tgt_data = f_data; tgt = 1'b1;
        rise_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        while (!done && cycles < 5000) begin
            if (busy) cycles++;
            if (inject && cycles == 37) begin
                start = 1'b1; op = ~f_op; port_addr = ~f_port;
                dev_type = ~f_dev; wr_data = ~f_data; div_half = f_half + 8'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        // R8: busy length and done timing
        chk(cycles == 128 * (int'(f_half) + 1), "R8", "busy cycles", 64'(cycles),
            64'(128 * (int'(f_half) + 1)));
        chk(done && !busy, "R8", "done with busy low", {62'd0, done, busy}, 64'h2);
        // R6 / R10: read data or held value
        if (is_rd) last_rd = f_data;
        chk(rd_data == last_rd, is_rd ? "R6" : "R10", "rd_data", 64'(rd_data), 64'(last_rd));
        @(negedge clk);
        chk(!done, "R8", "done width", 64'(done), 64'd0);
        chk(!mdc && !mdio_oe && !busy, "R1", "idle outputs",
            {61'd0, mdc, mdio_oe, busy}, 64'd0);
        chk(rise_cnt == 64, "R7", "mdc rising edges", 64'(rise_cnt), 64'd64);
        got_line = '0; got_oe = '0;
        for (int k = 0; k < 64; k++) begin
            got_line[63-k] = line_bits[k];
            got_oe[63-k]   = oe_bits[k];
        end
        mask   = is_rd ? {46'h3FFF_FFFF_FFFF, 18'd0} : 64'hFFFF_FFFF_FFFF_FFFF;
        exp_oe = mask;
        // R2 / R3 / R4: serial stream MSB first
        chk((got_line & mask) == (exp & mask), is_rd ? "R3" : "R4", "frame bits",
            got_line & mask, exp & mask);
        chk(got_line[63:30] == {32'hFFFF_FFFF, 2'b00}, "R2", "preamble and start",
            64'(got_line[63:30]), 64'h3_FFFF_FFFC);
        // R5 / R4: drive enable pattern
        chk(got_oe == exp_oe, is_rd ? "R5" : "R4", "oe pattern", got_oe, exp_oe);
        if (inject) begin
            repeat (20) @(negedge clk);
            chk(!busy && !mdc, "R9", "no frame after ignored start",
                {62'd0, busy, mdc}, 64'd0);
        end
    endtask

    // op, port, dev, payload/returned data, div_half
    localparam logic [29:0] VECS [6] = '{
        {2'b01, 5'h00, 5'h01, 16'hA5C3, 2'd0},
        {2'b11, 5'h15, 5'h05, 16'h8001, 2'd0},
        {2'b00, 5'h1F, 5'h03, 16'h0001, 2'd1},
        {2'b10, 5'h0A, 5'h02, 16'h7FFE, 2'd2},
        {2'b11, 5'h01, 5'h04, 16'h0000, 2'd1},
        {2'b01, 5'h1E, 5'h00, 16'hFFFF, 2'd0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mdc && !busy && !done && !mdio_oe && rd_data == 16'h0, "R1", "reset state",
            {44'd0, rd_data, mdc, busy, done, mdio_oe}, 64'd0);
        for (int i = 0; i < 6; i++) begin
            run_frame(VECS[i][29:28], VECS[i][27:23], VECS[i][22:18],
                      VECS[i][17:2], {6'd0, VECS[i][1:0]}, 1'b0);
        end
        // R9: start ignored mid-frame on a read
        run_frame(2'b11, 5'h11, 5'h03, 16'hC3A5, 8'd1, 1'b1);
        // R6 / R7: longer half period makes late sampling matter
        run_frame(2'b10, 5'h1F, 5'h1F, 16'h5AA5, 8'd5, 1'b0);
        // R10: address frame keeps the last read value
        run_frame(2'b00, 5'h02, 5'h01, 16'h1234, 8'd0, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule